// File: doc/BRIEF.md
# Rotate-Extend-Accumulate Unit

A 32-bit datapath step for a processor's execute stage. It takes a source word, rotates it right by a whole number of bytes, and pulls out a byte, a halfword or a pair of bytes. That field is sign- or zero-extended, and the extended value can then be added to a second operand.

The byte and halfword forms produce a single 32-bit value and accumulate with an ordinary 32-bit add. The dual-byte form works on two 16-bit lanes. Bits 7:0 of the rotated word fill the low lane and bits 23:16 fill the high lane, each widened to 16 bits. The accumulate is then done lane by lane, with no carry from bit 15 into bit 16.

The decoder drives `acc_en_i` low when the instruction names no accumulate register. The result is then the extended value alone. A parameter chooses whether the result is registered for one cycle or passed through combinationally.

Top module: `rext_acc_unit`

## Requirements
- R1: The source word is rotated right by `rot_i`×8 bits (0, 8, 16 or 24) before extraction.
- R2: Byte extraction takes bits 7:0 of the rotated word. `op_i`=3'b000 sign-extends it to 32 bits and 3'b100 zero-extends it.
- R3: Halfword extraction takes bits 15:0 of the rotated word. `op_i`=3'b001 sign-extends it and 3'b101 zero-extends it.
- R4: Dual-byte extraction is selected by `op_i`=3'b010 (signed) or 3'b110 (unsigned). It places rotated bits 7:0, extended to 16 bits, in result bits 15:0, and rotated bits 23:16, extended the same way, in result bits 31:16.
- R5: With `acc_en_i`=0 the result equals the extended value, whatever the value of `acc_i`.
- R6: With `acc_en_i`=1 and a byte or halfword op, the result is (extended + `acc_i`) mod 2^32. A carry out of bit 15 propagates into the upper half.
- R7: With `acc_en_i`=1 and a dual-byte op, each 16-bit lane is (lane of extended + lane of `acc_i`) mod 2^16. No carry passes from bit 15 to bit 16.
- R8: The reserved op codes 3'b011 and 3'b111 give an extended value of zero. The result is therefore `acc_i` when accumulating and 0 otherwise.
- R9: With `REG_OUT`=1 (the default) the result appears one clock after the inputs are sampled. While `rst_ni` is low, `res_o` is 0 without waiting for a clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Word that is rotated and extended |
| acc_i | input | 32 | Accumulate operand |
| rot_i | input | 2 | Rotate amount in bytes |
| op_i | input | 3 | Extract select: bit 2 = unsigned, bits 1:0 = byte/half/dual/reserved |
| acc_en_i | input | 1 | Add `acc_i` to the extended value |
| res_o | output | 32 | Result |

## Verification
The bench aims at the points where an extend-and-add unit usually goes wrong:
- **Dual-byte lane carry.** A low lane that sums to 0x10000 is checked. A unit that let the carry cross bit 15 would show a high lane one too large.
- **Byte/halfword carry.** The opposite case is also checked. A byte accumulate whose carry must ripple past bit 15 would come out 0x10000 short if the lane mask were applied to every op.
- **Rotation.** Each rotate amount is checked on a word whose bytes are all distinct. A wrong direction or a wrong step size would select the wrong byte.
- **Sign bit and reserved codes.** Sign-extension from bit 7 and bit 15 is checked. The reserved op codes are checked too, because a sloppy decode would leak bits of the source into the result.

// File: rtl/rext_pkg.sv
package rext_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned HALF_W = 16;
  localparam int unsigned ROT_W  = 2;

  // op[2] = unsigned, op[1:0] = field kind
  typedef enum logic [2:0] {
    EXT_SB = 3'b000,
    EXT_SH = 3'b001,
    EXT_SD = 3'b010,
    EXT_UB = 3'b100,
    EXT_UH = 3'b101,
    EXT_UD = 3'b110
  } ext_op_e;

  localparam logic [1:0] KIND_BYTE = 2'b00;
  localparam logic [1:0] KIND_HALF = 2'b01;
  localparam logic [1:0] KIND_DUAL = 2'b10;

  function automatic logic op_is_dual(logic [2:0] op);
    return op[1:0] == KIND_DUAL;
  endfunction
endpackage

// File: rtl/rext_rotator.sv
module rext_rotator #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned STEP_W = 8,
  parameter int unsigned ROT_W  = 2
) (
  input  logic [DATA_W-1:0] din_i,
  input  logic [ROT_W-1:0]  rot_i,
  output logic [DATA_W-1:0] dout_o
);
  localparam int unsigned N_ROT = 1 << ROT_W;

  logic [DATA_W-1:0] cand [N_ROT];

  for (genvar k = 0; k < N_ROT; k++) begin : g_cand
    if (k == 0) begin : g_zero
      assign cand[k] = din_i;
    end else begin : g_rot
      assign cand[k] = {din_i[k*STEP_W-1:0], din_i[DATA_W-1:k*STEP_W]};
    end
  end

  assign dout_o = cand[rot_i];
endmodule

// File: rtl/rext_extender.sv
module rext_extender #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned HALF_W = 16
) (
  input  logic [DATA_W-1:0] din_i,
  input  logic [2:0]        op_i,
  output logic [DATA_W-1:0] ext_o
);
  import rext_pkg::*;

  localparam int unsigned LANES = DATA_W / HALF_W;

  logic              sgn;
  logic [DATA_W-1:0] ext_byte, ext_half, ext_dual;

  assign sgn = ~op_i[2];

  assign ext_byte = {{(DATA_W-BYTE_W){sgn & din_i[BYTE_W-1]}}, din_i[BYTE_W-1:0]};
  assign ext_half = {{(DATA_W-HALF_W){sgn & din_i[HALF_W-1]}}, din_i[HALF_W-1:0]};

  // each lane widens its own low byte
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    localparam int unsigned B = l * HALF_W;
    assign ext_dual[B +: HALF_W] =
      {{(HALF_W-BYTE_W){sgn & din_i[B+BYTE_W-1]}}, din_i[B +: BYTE_W]};
  end

  always_comb begin
    unique case (op_i[1:0])
      KIND_BYTE: ext_o = ext_byte;
      KIND_HALF: ext_o = ext_half;
      KIND_DUAL: ext_o = ext_dual;
      default:   ext_o = '0;
    endcase
  end
endmodule

// File: rtl/rext_accum.sv
module rext_accum #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned HALF_W = 16
) (
  input  logic [DATA_W-1:0] ext_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic              acc_en_i,
  input  logic              dual_i,
  output logic [DATA_W-1:0] sum_o
);
  localparam int unsigned LANES = DATA_W / HALF_W;

  logic [DATA_W-1:0] msb_mask;
  logic [DATA_W-1:0] full_sum, lane_sum;

  for (genvar l = 0; l < DATA_W; l++) begin : g_mask
    assign msb_mask[l] = ((l % HALF_W) == HALF_W - 1) && (l < LANES * HALF_W);
  end

  assign full_sum = ext_i + acc_i;
  // strip lane MSBs so no carry leaves a lane, then restore them by XOR
  assign lane_sum = ((ext_i & ~msb_mask) + (acc_i & ~msb_mask))
                  ^ ((ext_i ^ acc_i) & msb_mask);

  always_comb begin
    if (!acc_en_i)   sum_o = ext_i;
    else if (dual_i) sum_o = lane_sum;
    else             sum_o = full_sum;
  end
endmodule

// File: rtl/rext_acc_unit.sv
module rext_acc_unit #(
  parameter int unsigned DATA_W  = rext_pkg::WORD_W,
  parameter int unsigned ROT_W   = rext_pkg::ROT_W,
  parameter bit          REG_OUT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] acc_i,
  input  logic [ROT_W-1:0]  rot_i,
  input  logic [2:0]        op_i,
  input  logic              acc_en_i,
  output logic [DATA_W-1:0] res_o
);
  import rext_pkg::*;

  logic [DATA_W-1:0] rotated, extended, summed;

  rext_rotator #(.DATA_W(DATA_W), .STEP_W(BYTE_W), .ROT_W(ROT_W)) u_rot (
    .din_i (src_i),
    .rot_i (rot_i),
    .dout_o(rotated)
  );

  rext_extender #(.DATA_W(DATA_W), .BYTE_W(BYTE_W), .HALF_W(HALF_W)) u_ext (
    .din_i(rotated),
    .op_i (op_i),
    .ext_o(extended)
  );

  rext_accum #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_acc (
    .ext_i   (extended),
    .acc_i   (acc_i),
    .acc_en_i(acc_en_i),
    .dual_i  (op_is_dual(op_i)),
    .sum_o   (summed)
  );

  if (REG_OUT) begin : g_reg
    logic [DATA_W-1:0] res_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) res_q <= '0;
      else         res_q <= summed;
    end
    assign res_o = res_q;
  end else begin : g_comb
    logic unused_clk;
    assign unused_clk = clk_i ^ rst_ni;
    assign res_o = summed;
  end
endmodule

// File: rtl/rext_acc_chk.sv
module rext_acc_chk #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ROT_W   = 2,
  parameter bit          REG_OUT = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [DATA_W-1:0] src_i,
  input logic [DATA_W-1:0] acc_i,
  input logic [ROT_W-1:0]  rot_i,
  input logic [2:0]        op_i,
  input logic              acc_en_i,
  input logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] src_d, acc_d;
  logic [ROT_W-1:0]  rot_d;
  logic [2:0]        op_d;
  logic              en_d, v_d;

  // align inputs with the result they produced
  if (REG_OUT) begin : g_dly
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        src_d <= '0; acc_d <= '0; rot_d <= '0; op_d <= '0; en_d <= 1'b0; v_d <= 1'b0;
      end else begin
        src_d <= src_i; acc_d <= acc_i; rot_d <= rot_i; op_d <= op_i;
        en_d <= acc_en_i; v_d <= 1'b1;
      end
    end
  end else begin : g_now
    assign src_d = src_i; assign acc_d = acc_i; assign rot_d = rot_i;
    assign op_d = op_i; assign en_d = acc_en_i; assign v_d = 1'b1;
  end

  assert_rot_one_byte_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_d && !en_d && op_d == 3'b100 && rot_d == 2'd1) |-> res_o == {24'h0, src_d[15:8]});

  assert_sbyte_sign_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_d && !en_d && op_d == 3'b000) |-> res_o[31:8] == {24{res_o[7]}});

  assert_uhalf_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_d && !en_d && op_d == 3'b101) |-> res_o[31:16] == 16'h0);

  assert_udual_layout_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_d && !en_d && op_d == 3'b110 && rot_d == 2'd0)
      |-> res_o == {8'h0, src_d[23:16], 8'h0, src_d[7:0]});

  assert_ubyte_acc_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_d && en_d && op_d == 3'b100 && rot_d == 2'd0)
      |-> res_o == acc_d + {24'h0, src_d[7:0]});

  assert_dual_low_lane_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_d && en_d && op_d == 3'b110 && rot_d == 2'd0)
      |-> res_o[15:0] == 16'(acc_d[15:0] + {8'h0, src_d[7:0]}));

  assert_reserved_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (v_d && op_d[1:0] == 2'b11) |-> res_o == (en_d ? acc_d : '0));

  assert_reset_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !v_d |-> res_o == '0);
endmodule

bind rext_acc_unit rext_acc_chk #(.DATA_W(DATA_W), .ROT_W(ROT_W), .REG_OUT(REG_OUT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .src_i(src_i), .acc_i(acc_i), .rot_i(rot_i),
  .op_i(op_i), .acc_en_i(acc_en_i), .res_o(res_o)
);

// File: tb/rext_acc_unit_tb.sv
module rext_acc_unit_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [31:0] src_i = '0, acc_i = '0;
  logic [1:0]  rot_i = '0;
  logic [2:0]  op_i = '0;
  logic        acc_en_i = 1'b0;
  logic [31:0] res_o;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  rext_acc_unit u_dut (.*);

  function automatic logic [31:0] model(logic [31:0] s, logic [31:0] a,
                                        logic [1:0] r, logic [2:0] op, logic en);
    logic [63:0] dbl;
    logic [31:0] w, e;
    logic [15:0] lo, hi;
    dbl = {s, s} >> (r * 8);
    w = dbl[31:0];
    case (op)
      3'b000: e = {{24{w[7]}}, w[7:0]};
      3'b100: e = {24'h0, w[7:0]};
      3'b001: e = {{16{w[15]}}, w[15:0]};
      3'b101: e = {16'h0, w[15:0]};
      3'b010: e = {{8{w[23]}}, w[23:16], {8{w[7]}}, w[7:0]};
      3'b110: e = {8'h0, w[23:16], 8'h0, w[7:0]};
      default: e = 32'h0;
    endcase
    if (!en) return e;
    if (op[1:0] == 2'b10) begin
      lo = e[15:0] + a[15:0];
      hi = e[31:16] + a[31:16];
      return {hi, lo};
    end
    return e + a;
  endfunction

  function automatic string tag_of(logic [2:0] op, logic en);
    string t;
    case (op[1:0])
      2'b00: t = "R1 R2";
      2'b01: t = "R1 R3";
      2'b10: t = "R1 R4";
      default: t = "R8";
    endcase
    if (!en) t = {t, " R5"};
    else if (op[1:0] == 2'b10) t = {t, " R7"};
    else if (op[1:0] != 2'b11) t = {t, " R6"};
    return {t, " R9"};
  endfunction

  task automatic check(logic [31:0] exp, string tag);
    n_tests++;
    if (res_o !== exp) begin
      n_fail++;
      $display("FAIL %s: res_o=%08h expected %08h", tag, res_o, exp);
    end
  endtask

  task automatic apply(logic [31:0] s, logic [31:0] a, logic [1:0] r,
                       logic [2:0] op, logic en, string tag);
    @(negedge clk_i);
    src_i = s; acc_i = a; rot_i = r; op_i = op; acc_en_i = en;
    @(negedge clk_i);
    check(model(s, a, r, op, en), tag);
  endtask

  initial begin
    int unsigned seed_set;
    seed_set = $urandom(32'd20240611);
    repeat (3) @(negedge clk_i);
    check(32'h0, "R9 reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(32'h0, "R9 idle after reset");

    apply(32'h11223344, 32'h0, 2'd0, 3'b100, 1'b0, "R1 rot0");
    check(32'h00000044, "R1 rot0 literal");
    apply(32'h11223344, 32'h0, 2'd1, 3'b100, 1'b0, "R1 rot1");
    check(32'h00000033, "R1 rot1 literal");
    apply(32'h11223344, 32'h0, 2'd2, 3'b100, 1'b0, "R1 rot2");
    check(32'h00000022, "R1 rot2 literal");
    apply(32'h11223344, 32'h0, 2'd3, 3'b100, 1'b0, "R1 rot3");
    check(32'h00000011, "R1 rot3 literal");
    apply(32'h00000080, 32'h0, 2'd0, 3'b000, 1'b0, "R2 sign byte");
    check(32'hFFFFFF80, "R2 sign byte literal");
    apply(32'h00008000, 32'h0, 2'd0, 3'b001, 1'b0, "R3 sign half");
    check(32'hFFFF8000, "R3 sign half literal");
    apply(32'h00800080, 32'h0, 2'd0, 3'b010, 1'b0, "R4 sign dual");
    check(32'hFF80FF80, "R4 sign dual literal");
    apply(32'h00000080, 32'hFFFFFFFF, 2'd0, 3'b100, 1'b0, "R5 acc ignored");
    check(32'h00000080, "R5 acc ignored literal");
    apply(32'h000000FF, 32'h0000FF01, 2'd0, 3'b100, 1'b1, "R6 carry past bit 15");
    check(32'h00010000, "R6 carry literal");
    apply(32'h00FF00FF, 32'h0001FF01, 2'd0, 3'b110, 1'b1, "R7 lane carry blocked");
    check(32'h01000000, "R7 lane literal");
    apply(32'hDEADBEEF, 32'h12345678, 2'd2, 3'b011, 1'b1, "R8 reserved acc");
    check(32'h12345678, "R8 reserved acc literal");
    apply(32'hDEADBEEF, 32'h12345678, 2'd1, 3'b111, 1'b0, "R8 reserved no acc");
    check(32'h0, "R8 reserved literal");

    for (int i = 0; i < 600; i++) begin
      logic [2:0] op;
      logic en;
      op = 3'($urandom);
      en = 1'($urandom);
      apply($urandom, $urandom, 2'($urandom), op, en, tag_of(op, en));
    end

    @(negedge clk_i);
    rst_ni = 1'b0;
    #1;
    check(32'h0, "R9 async reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    apply(32'h0000007F, 32'h00000001, 2'd0, 3'b000, 1'b1, "R6 after reset");

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule